// File: doc/BRIEF.md
# Octant-Folded FFT Twiddle Factor Generator

This block delivers complex FFT twiddle factors W = cos(2πe/N) − j·sin(2πe/N) to a butterfly datapath at a rate of one factor per clock. The caller does not pass a table address. It presents a request strobe together with a transform-length code, a radix mode, a stage number, a butterfly group number and a butterfly leg. The block derives the exponent e from these fields and scales it to the largest supported length. It folds the scaled exponent into the first eighth of a turn and reads cosine and sine there. It then rebuilds the full factor by exchanging and negating the two parts.

The coefficient table holds only one octant. For the default largest length of 1024 that is 129 cosine/sine pairs, each in signed Q1.15. The table is produced at elaboration from an integer series, and smaller lengths reuse it by scaling the exponent. The datapath has three registered stages: exponent and fold, table read, and sign/swap correction. A result therefore leaves the block three clocks after its request, and back-to-back requests stream without gaps.

Top module: `twf_gen`

## Requirements
- R1: While reset is held, and in every cycle where `tw_vld` is low, `tw_re` and `tw_im` are both zero.
- R2: `tw_vld` rises exactly three clock cycles after a cycle in which `req_vld` is sampled high. Requests on consecutive cycles produce results on consecutive cycles, in order.
- R3: `len_sel` code c selects N = 16·2^c for c = 0..6 (16 to 1024). Code 7 is treated as N = 1024.
- R4: In radix-4 mode, and in every mixed-mode stage other than the last, the exponent is e = (leg·grp·4^stage) mod N. Each part of the result lies within 1 LSB of round(x·2^15), where that value is limited to the range −32767..+32767.
- R5: `tw_re` carries cos(2πe/N) and `tw_im` carries −sin(2πe/N). For example, N = 16 with e = 4 gives `tw_re` ≈ 0 and `tw_im` ≈ −32767.
- R6: An exponent of zero yields exactly `tw_re` = 0x7FFF and `tw_im` = 0x0000.
- R7: In mixed mode (`mode_mixed` = 1), the stage numbered floor(log2 N / 2) is the radix-2 stage. Its exponent is (leg[0]·grp·N/2) mod N. The output is exactly −32767 + j0 when leg[0] and grp[0] are both 1, and exactly +32767 + j0 otherwise. leg[1] has no effect in that stage.
- R8: Exponents wrap modulo N. A group number of N or more gives the same factor as the group number reduced modulo N.
- R9: Neither output part ever takes the value −32768 while `tw_vld` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_vld | input | 1 | Request strobe, one factor per high cycle |
| len_sel | input | 3 | Transform-length code, N = 16·2^code |
| mode_mixed | input | 1 | 0: radix-4 ordering; 1: mixed radix-4/2 ordering |
| stage | input | 3 | Butterfly stage number, 0 first |
| grp | input | 10 | Butterfly group number within the stage |
| leg | input | 2 | Butterfly leg, 0..3 |
| tw_vld | output | 1 | Result valid |
| tw_re | output | 16 | Real part, signed Q1.15 |
| tw_im | output | 16 | Imaginary part, signed Q1.15 |

## Verification
Every request result, and every idle cycle, is due at the outputs three rising edges after the falling edge on which the bench drove it. The bench therefore keeps one expected entry per driven cycle in a queue. It pops an entry only once three entries are ahead of the current drive, and it samples on the falling edge before driving the next request. The exact-value cases (zero exponent and the radix-2 stage) and the ±1 LSB cases are compared in that same cycle. Idle gaps inside the sweeps confirm that the valid flag tracks the three-cycle delay rather than any fixed pattern.

// File: rtl/twf_pkg.sv
package twf_pkg;

   // pi scaled by 2^30
   localparam longint PI_Q30 = 64'sd3373259426;

   typedef enum logic {
      TW_RADIX4  = 1'b0,
      TW_MIXED42 = 1'b1
   } twf_mode_e;

   typedef struct packed {
      logic       vld;
      logic       swap;
      logic [1:0] quad;
   } twf_ctl_t;

   // cos or sin of (pi/4)*idx/oct, Q30, by a truncated power series
   function automatic longint twf_wave_q30(input int idx, input int oct, input bit want_cos);
      longint x;
      longint x2;
      longint term;
      longint sum;
      longint d;
      x    = (PI_Q30 * longint'(idx)) / longint'(4 * oct);
      x2   = (x * x) >>> 30;
      term = want_cos ? (longint'(1) <<< 30) : x;
      sum  = term;
      for (int n = 1; n <= 6; n++) begin
         d    = want_cos ? longint'((2 * n - 1) * (2 * n)) : longint'((2 * n) * (2 * n + 1));
         term = -(((term * x2) >>> 30) / d);
         sum  = sum + term;
      end
      return sum;
   endfunction

   // Q30 to Q(frac) with rounding, clipped at +1 - 1 LSB
   function automatic longint twf_to_fixed(input longint v, input int frac);
      longint r;
      longint lim;
      r   = (v + (longint'(1) <<< (29 - frac))) >>> (30 - frac);
      lim = (longint'(1) <<< frac) - 1;
      if (r > lim) r = lim;
      return r;
   endfunction

endpackage

// File: rtl/twf_expgen.sv
module twf_expgen #(
   parameter int MAX_LOG2 = 10,
   parameter int MIN_LOG2 = 4,
   parameter int SEL_W    = 3,
   parameter int STG_W    = 3,
   parameter int GRP_W    = 10,
   parameter bit PROD_MUL = 1'b0
) (
   input  logic [SEL_W-1:0]    len_sel,
   input  twf_pkg::twf_mode_e  mode,
   input  logic [STG_W-1:0]    stage,
   input  logic [GRP_W-1:0]    grp,
   input  logic [1:0]          leg,
   output logic [MAX_LOG2-1:0] k_scaled
);
   import twf_pkg::*;

   localparam int MAX_CODE = MAX_LOG2 - MIN_LOG2;
   localparam int LOG_W    = $clog2(MAX_LOG2 + 1);
   localparam int PW       = GRP_W + 2;

   logic [SEL_W-1:0] code_c;
   logic [LOG_W-1:0] log2n;
   logic [STG_W-1:0] last_stg;
   logic [PW-1:0]    prod;
   logic [7:0]       shamt;

   // leg * grp: a real multiplier or two gated adds
   generate
      if (PROD_MUL) begin : g_mul
         assign prod = PW'(grp) * PW'(leg);
      end else begin : g_add
         assign prod = (leg[0] ? PW'(grp) : '0) + (leg[1] ? PW'({grp, 1'b0}) : '0);
      end
   endgenerate

   always_comb begin
      code_c   = (len_sel > SEL_W'(MAX_CODE)) ? SEL_W'(MAX_CODE) : len_sel;
      log2n    = LOG_W'(MIN_LOG2) + LOG_W'(code_c);
      last_stg = STG_W'(log2n >> 1);
      // 4^stage for the exponent, then scale from N up to the full table turn
      shamt    = 8'({stage, 1'b0}) + 8'(MAX_LOG2) - 8'(log2n);
      if (mode == TW_MIXED42 && stage == last_stg) begin
         k_scaled = (leg[0] & grp[0]) ? {1'b1, {(MAX_LOG2-1){1'b0}}} : '0;
      end else begin
         k_scaled = MAX_LOG2'(prod) << shamt;
      end
   end

endmodule

// File: rtl/twf_fold.sv
module twf_fold #(
   parameter int MAX_LOG2 = 10,
   localparam int IW      = MAX_LOG2 - 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_vld,
   input  logic [MAX_LOG2-1:0]   k_scaled,
   output twf_pkg::twf_ctl_t     ctl,
   output logic [IW-1:0]         idx
);
   import twf_pkg::*;

   localparam int RW  = MAX_LOG2 - 3;
   localparam int OCT = 1 << RW;

   logic          half;
   logic [RW-1:0] r;
   logic [IW-1:0] idx_c;

   always_comb begin
      half  = k_scaled[MAX_LOG2-3];
      r     = k_scaled[RW-1:0];
      // upper half of an octant mirrors around the 45-degree point
      idx_c = half ? (IW'(OCT) - {1'b0, r}) : {1'b0, r};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl <= '0;
         idx <= '0;
      end else begin
         ctl.vld  <= in_vld;
         ctl.swap <= half;
         ctl.quad <= k_scaled[MAX_LOG2-1:MAX_LOG2-2];
         idx      <= idx_c;
      end
   end

endmodule

// File: rtl/twf_rom.sv
module twf_rom #(
   parameter int MAX_LOG2 = 10,
   parameter int DW       = 16,
   localparam int IW      = MAX_LOG2 - 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  twf_pkg::twf_ctl_t ctl_in,
   input  logic [IW-1:0]     idx,
   output twf_pkg::twf_ctl_t ctl_out,
   output logic [DW-1:0]     cos_q,
   output logic [DW-1:0]     sin_q
);
   import twf_pkg::*;

   localparam int OCT   = 1 << (MAX_LOG2 - 3);
   localparam int DEPTH = OCT + 1;

   logic [DW-1:0] tab_c [DEPTH];
   logic [DW-1:0] tab_s [DEPTH];

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_ent
         localparam logic [DW-1:0] CV = DW'(twf_to_fixed(twf_wave_q30(i, OCT, 1'b1), DW - 1));
         localparam logic [DW-1:0] SV = DW'(twf_to_fixed(twf_wave_q30(i, OCT, 1'b0), DW - 1));
         assign tab_c[i] = CV;
         assign tab_s[i] = SV;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_out <= '0;
         cos_q   <= '0;
         sin_q   <= '0;
      end else begin
         ctl_out <= ctl_in;
         cos_q   <= tab_c[idx];
         sin_q   <= tab_s[idx];
      end
   end

endmodule

// File: rtl/twf_fix.sv
module twf_fix #(
   parameter int DW = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  twf_pkg::twf_ctl_t  ctl,
   input  logic [DW-1:0]      cos_q,
   input  logic [DW-1:0]      sin_q,
   output logic               out_vld,
   output logic signed [DW-1:0] out_re,
   output logic signed [DW-1:0] out_im
);
   import twf_pkg::*;

   logic [DW-1:0] c_phi;
   logic [DW-1:0] s_phi;
   logic [DW-1:0] c_all;
   logic [DW-1:0] s_all;

   always_comb begin
      c_phi = ctl.swap ? sin_q : cos_q;
      s_phi = ctl.swap ? cos_q : sin_q;
      unique case (ctl.quad)
         2'd0: begin c_all = c_phi;  s_all = s_phi;  end
         2'd1: begin c_all = -s_phi; s_all = c_phi;  end
         2'd2: begin c_all = -c_phi; s_all = -s_phi; end
         default: begin c_all = s_phi; s_all = -c_phi; end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld <= 1'b0;
         out_re  <= '0;
         out_im  <= '0;
      end else begin
         out_vld <= ctl.vld;
         out_re  <= ctl.vld ? c_all : '0;
         out_im  <= ctl.vld ? -s_all : '0;
      end
   end

endmodule

// File: rtl/twf_gen.sv
module twf_gen #(
   parameter int MAX_LOG2 = 10,
   parameter int MIN_LOG2 = 4,
   parameter int DW       = 16,
   parameter bit PROD_MUL = 1'b0,
   localparam int SEL_W   = $clog2(MAX_LOG2 - MIN_LOG2 + 1),
   localparam int STG_W   = $clog2(MAX_LOG2 / 2 + 1),
   localparam int GRP_W   = MAX_LOG2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_vld,
   input  logic [SEL_W-1:0]     len_sel,
   input  logic                 mode_mixed,
   input  logic [STG_W-1:0]     stage,
   input  logic [GRP_W-1:0]     grp,
   input  logic [1:0]           leg,
   output logic                 tw_vld,
   output logic signed [DW-1:0] tw_re,
   output logic signed [DW-1:0] tw_im
);
   import twf_pkg::*;

   localparam int IW = MAX_LOG2 - 2;

   generate
      if (MIN_LOG2 < 3 || MAX_LOG2 <= MIN_LOG2) begin : g_bad_len
         $error("twf_gen: length range must satisfy 3 <= MIN_LOG2 < MAX_LOG2");
      end
      if (DW < 8 || DW > 24) begin : g_bad_dw
         $error("twf_gen: DW must lie in 8..24");
      end
   endgenerate

   twf_mode_e         mode;
   logic [MAX_LOG2-1:0] k_scaled;
   twf_ctl_t          ctl_f;
   twf_ctl_t          ctl_r;
   logic [IW-1:0]     idx_f;
   logic [DW-1:0]     cos_r;
   logic [DW-1:0]     sin_r;

   assign mode = mode_mixed ? TW_MIXED42 : TW_RADIX4;

   twf_expgen #(
      .MAX_LOG2 (MAX_LOG2),
      .MIN_LOG2 (MIN_LOG2),
      .SEL_W    (SEL_W),
      .STG_W    (STG_W),
      .GRP_W    (GRP_W),
      .PROD_MUL (PROD_MUL)
   ) u_exp (
      .len_sel  (len_sel),
      .mode     (mode),
      .stage    (stage),
      .grp      (grp),
      .leg      (leg),
      .k_scaled (k_scaled)
   );

   twf_fold #(.MAX_LOG2(MAX_LOG2)) u_fold (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_vld   (req_vld),
      .k_scaled (k_scaled),
      .ctl      (ctl_f),
      .idx      (idx_f)
   );

   twf_rom #(.MAX_LOG2(MAX_LOG2), .DW(DW)) u_rom (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctl_in  (ctl_f),
      .idx     (idx_f),
      .ctl_out (ctl_r),
      .cos_q   (cos_r),
      .sin_q   (sin_r)
   );

   twf_fix #(.DW(DW)) u_fix (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctl     (ctl_r),
      .cos_q   (cos_r),
      .sin_q   (sin_r),
      .out_vld (tw_vld),
      .out_re  (tw_re),
      .out_im  (tw_im)
   );

endmodule

// File: rtl/twf_gen_chk.sv
module twf_gen_chk #(
   parameter int MAX_LOG2 = 10,
   parameter int MIN_LOG2 = 4,
   parameter int DW       = 16,
   localparam int SEL_W   = $clog2(MAX_LOG2 - MIN_LOG2 + 1),
   localparam int STG_W   = $clog2(MAX_LOG2 / 2 + 1),
   localparam int GRP_W   = MAX_LOG2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 req_vld,
   input logic [SEL_W-1:0]     len_sel,
   input logic                 mode_mixed,
   input logic [STG_W-1:0]     stage,
   input logic [GRP_W-1:0]     grp,
   input logic [1:0]           leg,
   input logic                 tw_vld,
   input logic signed [DW-1:0] tw_re,
   input logic signed [DW-1:0] tw_im
);
   localparam logic signed [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
   localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};
   localparam int MAXI     = (1 << (DW - 1)) - 1;
   localparam int MAX_CODE = MAX_LOG2 - MIN_LOG2;

   logic [1:0] since_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   function automatic logic [STG_W-1:0] radix2_stage(input logic [SEL_W-1:0] code);
      int c;
      c = (int'(code) > MAX_CODE) ? MAX_CODE : int'(code);
      return STG_W'((MIN_LOG2 + c) / 2);
   endfunction

   function automatic int mag(input logic signed [DW-1:0] v);
      return (v < 0) ? -int'(v) : int'(v);
   endfunction

   // R1
   a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !tw_vld |-> (tw_re == '0 && tw_im == '0));

   // R2
   a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd3) |-> (tw_vld == $past(req_vld, 3)));

   // R6
   a_r6_zero_exp: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd3 && tw_vld && $past(leg, 3) == 2'b00) |-> (tw_re == MAXV && tw_im == '0));

   // R7
   a_r7_radix2_real: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd3 && tw_vld && $past(mode_mixed, 3) &&
       $past(stage, 3) == radix2_stage($past(len_sel, 3)))
      |-> (tw_im == '0 && tw_re == (($past(leg[0], 3) & $past(grp[0], 3)) ? -MAXV : MAXV)));

   // R9
   a_r9_no_min_code: assert property (@(posedge clk) disable iff (!rst_n)
      tw_vld |-> (tw_re != MINV && tw_im != MINV));

   // R4: a unit-magnitude factor keeps |re| + |im| at or above one
   a_r4_unit_norm: assert property (@(posedge clk) disable iff (!rst_n)
      tw_vld |-> (mag(tw_re) + mag(tw_im) >= MAXI - 2));

endmodule

bind twf_gen twf_gen_chk #(
   .MAX_LOG2 (MAX_LOG2),
   .MIN_LOG2 (MIN_LOG2),
   .DW       (DW)
) u_twf_chk (.*);

// File: tb/twf_gen_test.sv
`timescale 1ns/1ps
module twf_gen_test;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               req_vld = 1'b0;
   logic [2:0]         len_sel = '0;
   logic               mode_mixed = 1'b0;
   logic [2:0]         stage = '0;
   logic [9:0]         grp = '0;
   logic [1:0]         leg = '0;
   logic               tw_vld;
   logic signed [15:0] tw_re;
   logic signed [15:0] tw_im;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   typedef struct {
      bit    v;
      int    re;
      int    im;
      string tag;
      bit    exact;
   } exp_t;

   exp_t pend[$];

   always #2 clk = ~clk;

   twf_gen uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_vld    (req_vld),
      .len_sel    (len_sel),
      .mode_mixed (mode_mixed),
      .stage      (stage),
      .grp        (grp),
      .leg        (leg),
      .tw_vld     (tw_vld),
      .tw_re      (tw_re),
      .tw_im      (tw_im)
   );

   function automatic int rnd_sat(input real x);
      int r;
      r = $rtoi(x >= 0.0 ? x + 0.5 : x - 0.5);
      if (r > 32767) r = 32767;
      if (r < -32767) r = -32767;
      return r;
   endfunction

   function automatic exp_t model(input bit v, input int lsel, input bit mixed,
                                  input int stg, input int g, input int l, input string ovr);
      exp_t   x;
      int     code;
      int     n;
      int     lg;
      longint e;
      real    ang;
      bit     r2;
      x.v = v; x.re = 0; x.im = 0; x.tag = "R1"; x.exact = 1'b1;
      if (!v) return x;
      code = (lsel > 6) ? 6 : lsel;
      n    = 16 << code;
      lg   = 4 + code;
      r2   = mixed && (stg == lg / 2);
      if (r2) e = ((l % 2) == 1 && (g % 2) == 1) ? longint'(n / 2) : 0;
      else    e = (longint'(l) * longint'(g) * (longint'(1) << (2 * stg))) % longint'(n);
      ang  = 2.0 * 3.14159265358979323846 * real'(e) / real'(n);
      x.re = rnd_sat($cos(ang) * 32768.0);
      x.im = rnd_sat(-$sin(ang) * 32768.0);
      x.exact = 1'b0;
      x.tag   = "R4";
      if (g >= n) x.tag = "R8";
      if (lsel > 6) x.tag = "R3";
      if (r2) begin x.tag = "R7"; x.exact = 1'b1; end
      if (e == 0) begin
         x.tag = "R6"; x.exact = 1'b1; x.re = 32767; x.im = 0;
      end
      if (ovr != "") x.tag = ovr;
      return x;
   endfunction

   task automatic compare_one(input string tag, input string what, input int act,
                              input int expv, input bit exact);
      int d;
      d = act - expv;
      if (d < 0) d = -d;
      checks++;
      if ((exact && d != 0) || (!exact && d > 1)) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
      end
   endtask

   task automatic check_out();
      exp_t x;
      if (pend.size() == 3) begin
         x = pend.pop_front();
         checks++;
         if (tw_vld !== x.v) begin
            failures++;
            $display("FAIL R2 valid actual=%0b expected=%0b", tw_vld, x.v);
         end
         compare_one(x.tag, "re", int'(tw_re), x.re, x.exact);
         compare_one(x.tag, "im", int'(tw_im), x.im, x.exact);
         if (x.v) begin
            checks++;
            if (tw_re == 16'sh8000 || tw_im == 16'sh8000) begin
               failures++;
               $display("FAIL R9 range actual=%0d/%0d expected=no -32768", tw_re, tw_im);
            end
         end
      end
   endtask

   task automatic step(input bit v, input int lsel, input bit mixed, input int stg,
                       input int g, input int l, input string ovr = "");
      @(negedge clk);
      check_out();
      req_vld    = v;
      len_sel    = 3'(lsel);
      mode_mixed = mixed;
      stage      = 3'(stg);
      grp        = 10'(g);
      leg        = 2'(l);
      pend.push_back(model(v, lsel, mixed, stg, g, l, ovr));
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL R2 watchdog actual=running expected=finished");
         finish_run();
      end
   end

   initial begin
      exp_t idle;
      // R1: reset state
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         compare_one("R1", "vld", int'(tw_vld), 0, 1'b1);
         compare_one("R1", "re", int'(tw_re), 0, 1'b1);
         compare_one("R1", "im", int'(tw_im), 0, 1'b1);
      end
      @(negedge clk);
      rst_n = 1'b1;
      idle = model(1'b0, 0, 1'b0, 0, 0, 0, "");
      for (int i = 0; i < 3; i++) pend.push_back(idle);

      // R5: N=16, e=4 gives -j
      step(1'b1, 0, 1'b0, 0, 4, 1, "R5");
      // R5: N=16, e=8 gives -1, e=12 gives +j
      step(1'b1, 0, 1'b0, 0, 4, 2, "R5");
      step(1'b1, 0, 1'b0, 0, 4, 3, "R5");
      step(1'b0, 0, 1'b0, 0, 0, 0);

      // R4, R6, R7: every length, both orderings, with idle gaps (R2)
      for (int ls = 0; ls <= 6; ls++) begin
         for (int md = 0; md <= 1; md++) begin
            for (int st = 0; st <= (4 + ls) / 2; st++) begin
               for (int g = 0; g < (16 << ls) / 4; g++) begin
                  for (int l = 0; l < 4; l++) step(1'b1, ls, md[0], st, g, l);
                  if (g % 7 == 3) step(1'b0, ls, 1'b0, 0, 0, 0);
               end
            end
         end
      end

      // R3: code 7 behaves as N = 1024
      for (int st = 0; st <= 5; st++)
         for (int g = 0; g < 64; g++)
            for (int l = 0; l < 4; l++) step(1'b1, 7, 1'b0, st, g, l);

      // R8: group numbers beyond N wrap
      for (int st = 0; st <= 2; st++)
         for (int g = 16; g < 1024; g += 37)
            for (int l = 1; l < 4; l++) step(1'b1, 0, 1'b0, st, g, l);

      for (int i = 0; i < 4; i++) step(1'b0, 0, 1'b0, 0, 0, 0);
      done = 1'b1;
      finish_run();
   end

endmodule